// File: doc/BRIEF.md
# Circular Self-Test Register Ring

This block is a chain of self-test register cells that sit on the input and output lines of a circuit under test. The cells are closed into one ring, so the last cell feeds the first. A shared two-bit mode selects what every cell does on the next clock. A cell can capture its own system bit, shift the bit of its upstream neighbour, or capture its system bit XORed with that neighbour's bit. It can also keep its value.

In the XOR mode the ring does two jobs at once. It creates new stimulus for the logic it drives, and it folds the logic's responses into a running signature. A test is run in four steps. First a seed is shifted in through a serial input while the ring is opened. Then a session is launched that runs a programmable number of XOR clocks. Next the ring is compared with an expected signature, which produces a pass flag. Finally the signature can be shifted out serially if a closer look is needed. Registers that can be set directly are not meant to be placed in the ring.

Top module: `cstp_ring`

## Requirements
- R1: While reset is active, all cells, `busy`, `done` and `pass` read 0. Reset is asserted asynchronously and released on a clock edge.
- R2: Mode code 00 (system capture): on each clock, cell i loads `sys_d[i]`.
- R3: Mode code 01 (shift): cell 0 loads `scan_in` and cell i loads cell i-1. `scan_out` always shows the highest-index cell.
- R4: Mode code 10 (compaction): cell i loads `sys_d[i]` XOR cell i-1, and cell 0 takes the highest-index cell as its upstream neighbour.
- R5: Mode code 11 (keep): no cell changes, whatever `sys_d` and `scan_in` carry.
- R6: A `start` pulse while the block is idle samples `run_len`. It then runs exactly that many compaction clocks, during which `busy` is 1 and the external `mode` and `scan_in` have no effect.
- R7: The clock after the last compaction clock is a compare clock. At that edge, `busy` falls, `done` rises, and `pass` becomes 1 exactly when the ring equals `expect_sig`. The ring holds its value during the compare clock.
- R8: A session launched with `run_len` equal to 0 applies no compaction clock and goes straight to the compare clock.
- R9: A `start` pulse while `busy` is 1 is ignored. The running session keeps its original length.
- R10: `done` and `pass` keep their values until the next accepted `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Ring mode when idle: 00 capture, 01 shift, 10 compaction, 11 keep |
| sys_d | input | WIDTH | System data, one bit per cell |
| scan_in | input | 1 | Serial input to cell 0 in shift mode |
| scan_out | output | 1 | Serial output from the highest-index cell |
| q | output | WIDTH | Parallel cell contents |
| start | input | 1 | Launches a test session when idle |
| run_len | input | CNT_W | Number of compaction clocks in a session |
| expect_sig | input | WIDTH | Signature the ring is compared with |
| busy | output | 1 | A session is running or comparing |
| done | output | 1 | A session has finished |
| pass | output | 1 | The last comparison matched |

## Verification
Several properties are checked on every cycle. In capture, shift and compaction mode the next ring value is the one the mode defines, and keep mode leaves the ring unchanged. While a session runs, the ring behaves as in compaction mode. When `done` rises, `busy` falls in the same clock, and `done` holds until a start arrives. Other behaviours can only be shown by the bench scenarios, which compare against a reference signature: the exact number of compaction clocks a session applies, the value of `pass` for matching and mismatching signatures, the zero-length session, and a start pulse that arrives in mid-session. The bench also shows that the external mode and serial input are ignored while a session runs, and that a seed shifted in comes out through `scan_out` bit by bit.

// File: rtl/cstp_pkg.sv
package cstp_pkg;
  typedef enum logic [1:0] {
    MODE_SYS     = 2'b00,
    MODE_SHIFT   = 2'b01,
    MODE_COMPACT = 2'b10,
    MODE_KEEP    = 2'b11
  } cstp_mode_e;

  typedef enum logic [1:0] {
    SES_IDLE = 2'b00,
    SES_RUN  = 2'b01,
    SES_CMP  = 2'b10
  } ses_state_e;
endpackage

// File: rtl/cstp_rst_sync.sv
module cstp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cstp_cell.sv
module cstp_cell
  import cstp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cstp_mode_e mode,
  input  logic       sys_bit,
  input  logic       link_in,
  output logic       q
);
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = 1'b1;
    q_nxt = q;
    case (mode)
      MODE_SYS:     q_nxt = sys_bit;
      MODE_SHIFT:   q_nxt = link_in;
      MODE_COMPACT: q_nxt = sys_bit ^ link_in;
      default: begin
        q_nxt = q;
        q_en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/cstp_session.sv
module cstp_session
  import cstp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] run_len,
  input  cstp_mode_e       ext_mode,
  input  logic [WIDTH-1:0] ring_q,
  input  logic [WIDTH-1:0] expect_sig,
  output cstp_mode_e       eff_mode,
  output logic             run_active,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  ses_state_e       state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             done_q, done_nxt;
  logic             pass_q, pass_nxt;
  logic             cnt_en;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    cnt_en    = 1'b0;
    done_nxt  = done_q;
    pass_nxt  = pass_q;
    case (state_q)
      SES_IDLE: begin
        if (start) begin
          done_nxt  = 1'b0;
          pass_nxt  = 1'b0;
          cnt_nxt   = run_len;
          cnt_en    = 1'b1;
          state_nxt = (run_len == '0) ? SES_CMP : SES_RUN;
        end
      end
      SES_RUN: begin
        cnt_nxt = cnt_q - 1'b1;
        cnt_en  = 1'b1;
        if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) state_nxt = SES_CMP;
      end
      SES_CMP: begin
        pass_nxt  = (ring_q == expect_sig);
        done_nxt  = 1'b1;
        state_nxt = SES_IDLE;
      end
      default: state_nxt = SES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SES_IDLE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= done_nxt;
      pass_q  <= pass_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  always_comb begin
    case (state_q)
      SES_RUN: eff_mode = MODE_COMPACT;
      SES_CMP: eff_mode = MODE_KEEP;
      default: eff_mode = ext_mode;
    endcase
  end

  assign run_active = (state_q == SES_RUN);
  assign busy       = (state_q != SES_IDLE);
  assign done       = done_q;
  assign pass       = pass_q;
endmodule

// File: rtl/cstp_ring.sv
module cstp_ring
  import cstp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] sys_d,
  input  logic             scan_in,
  output logic             scan_out,
  output logic [WIDTH-1:0] q,
  input  logic             start,
  input  logic [CNT_W-1:0] run_len,
  input  logic [WIDTH-1:0] expect_sig,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  localparam int LAST = WIDTH - 1;

  logic             rst_sync_n;
  cstp_mode_e       eff_mode;
  logic             run_active;
  logic [WIDTH-1:0] link;

  cstp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cstp_session #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ses (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .run_len    (run_len),
    .ext_mode   (cstp_mode_e'(mode)),
    .ring_q     (q),
    .expect_sig (expect_sig),
    .eff_mode   (eff_mode),
    .run_active (run_active),
    .busy       (busy),
    .done       (done),
    .pass       (pass)
  );

  // Cell 0 is fed from the serial pin while shifting, else the ring closes.
  assign link[0] = (eff_mode == MODE_SHIFT) ? scan_in : q[LAST];

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_link
      assign link[gi] = q[gi-1];
    end
    for (gi = 0; gi < WIDTH; gi++) begin : g_cell
      cstp_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .mode    (eff_mode),
        .sys_bit (sys_d[gi]),
        .link_in (link[gi]),
        .q       (q[gi])
      );
    end
  endgenerate

  assign scan_out = q[LAST];
endmodule

// File: rtl/cstp_ring_chk.sv
module cstp_ring_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] sys_d,
  input logic             scan_in,
  input logic             start,
  input logic [WIDTH-1:0] q,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             run_active
);
  logic [WIDTH-1:0] rot_q;
  assign rot_q = {q[WIDTH-2:0], q[WIDTH-1]};

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (q == '0 && !busy && !done && !pass));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b00) |=> q == $past(sys_d));

  a_r3_shift_head: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b01) |=> (q[0] == $past(scan_in) && q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

  a_r4_compact: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b10) |=> q == $past(sys_d ^ rot_q));

  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode == 2'b11) |=> $stable(q));

  a_r6_session_compacts: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |=> q == $past(sys_d ^ rot_q));

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r10_pass_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(pass));
endmodule

bind cstp_ring cstp_ring_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mode       (mode),
  .sys_d      (sys_d),
  .scan_in    (scan_in),
  .start      (start),
  .q          (q),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .run_active (run_active)
);

// File: tb/sim_cstp_ring.sv
module sim_cstp_ring;
  localparam int W   = 8;
  localparam int CW  = 16;
  localparam int PER = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic [W-1:0]  sys_d;
  logic          scan_in;
  logic          scan_out;
  logic [W-1:0]  q;
  logic          start;
  logic [CW-1:0] run_len;
  logic [W-1:0]  expect_sig;
  logic          busy, done, pass;

  always #(PER/2) clk = ~clk;

  cstp_ring #(.WIDTH(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sys_d(sys_d), .scan_in(scan_in),
    .scan_out(scan_out), .q(q), .start(start), .run_len(run_len),
    .expect_sig(expect_sig), .busy(busy), .done(done), .pass(pass)
  );

  typedef struct {
    logic [W-1:0] q;
    logic         busy;
    logic         done;
    logic         pass;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk  = 0;
  int n_fail = 0;

  // Reference state built from the requirements.
  logic [W-1:0]  m_q;
  int            m_st;   // 0 idle, 1 running, 2 compare
  logic [CW-1:0] m_cnt;
  logic          m_done, m_pass;

  function automatic logic [W-1:0] stim(input int k);
    return W'(k * 37 + 5);
  endfunction

  function automatic logic [W-1:0] calc_sig(input logic [W-1:0] seed, input int len);
    logic [W-1:0] s = seed;
    for (int k = 0; k < len; k++) s = stim(k) ^ {s[W-2:0], s[W-1]};
    return s;
  endfunction

  task automatic step(input logic [1:0] md, input logic [W-1:0] sd, input logic si,
                      input logic st, input logic [CW-1:0] len, input string tag);
    logic [1:0]   e;
    logic [W-1:0] nq;
    exp_t         it;
    @(negedge clk);
    mode = md; sys_d = sd; scan_in = si; start = st; run_len = len;
    e = (m_st == 1) ? 2'b10 : (m_st == 2) ? 2'b11 : md;
    case (e)
      2'b00:   nq = sd;
      2'b01:   nq = {m_q[W-2:0], si};
      2'b10:   nq = sd ^ {m_q[W-2:0], m_q[W-1]};
      default: nq = m_q;
    endcase
    case (m_st)
      0: if (st) begin
           m_done = 1'b0; m_pass = 1'b0; m_cnt = len;
           m_st = (len == 0) ? 2 : 1;
         end
      1: begin
           if (m_cnt == 1) m_st = 2;
           m_cnt = m_cnt - 1'b1;
         end
      default: begin
           m_pass = (m_q == expect_sig);
           m_done = 1'b1;
           m_st   = 0;
         end
    endcase
    m_q = nq;
    it.q = m_q; it.busy = (m_st != 0); it.done = m_done; it.pass = m_pass; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic shift_seed(input logic [W-1:0] seed);
    for (int i = W - 1; i >= 0; i--) step(2'b01, 8'h99, seed[i], 1'b0, '0, "R3");
  endtask

  // During the run the external mode is shift and scan_in is 1 (R6); a
  // start pulse arrives at step 'poke' (R9).
  task automatic session(input int len, input int poke);
    step(2'b11, '0, 1'b0, 1'b1, CW'(len), "R6");
    for (int k = 0; k < len; k++)
      step(2'b01, stim(k), 1'b1, (k == poke), 16'd3, (k == poke) ? "R9" : "R6");
    step(2'b11, '0, 1'b0, 1'b0, '0, (len == 0) ? "R8" : "R7");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: compare results produced by the design with queued expectations.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t it;
        it = sbq.pop_front();
        n_chk++;
        if (q !== it.q || scan_out !== it.q[W-1] || busy !== it.busy ||
            done !== it.done || pass !== it.pass) begin
          n_fail++;
          $display("FAIL %s: q=%h so=%b busy=%b done=%b pass=%b expected q=%h so=%b busy=%b done=%b pass=%b",
                   it.tag, q, scan_out, busy, done, pass,
                   it.q, it.q[W-1], it.busy, it.done, it.pass);
        end
      end
    end
  end

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b11; sys_d = '0; scan_in = 1'b0; start = 1'b0;
    run_len = '0; expect_sig = '0;
    m_q = '0; m_st = 0; m_cnt = '0; m_done = 1'b0; m_pass = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (q !== '0 || busy !== 1'b0 || done !== 1'b0 || pass !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: q=%h busy=%b done=%b pass=%b expected all zero", q, busy, done, pass);
    end
    rst_n = 1'b1;
    repeat (3) step(2'b11, '0, 1'b0, 1'b0, '0, "R1");

    step(2'b00, 8'hA5, 1'b0, 1'b0, '0, "R2");
    step(2'b00, 8'h3C, 1'b1, 1'b0, '0, "R2");
    step(2'b00, 8'hFF, 1'b0, 1'b0, '0, "R2");

    step(2'b11, 8'h00, 1'b1, 1'b0, '0, "R5");
    step(2'b11, 8'h5A, 1'b0, 1'b0, '0, "R5");

    shift_seed(8'hC3);

    step(2'b10, 8'h12, 1'b0, 1'b0, '0, "R4");
    step(2'b10, 8'h81, 1'b1, 1'b0, '0, "R4");
    step(2'b10, 8'h00, 1'b0, 1'b0, '0, "R4");

    // Matching signature, with a stray start in mid-run.
    shift_seed(8'h1D);
    expect_sig = calc_sig(8'h1D, 20);
    session(20, 4);
    repeat (3) step(2'b11, 8'h77, 1'b1, 1'b0, '0, "R10");

    // Mismatching signature; start clears done and pass first.
    shift_seed(8'h6B);
    expect_sig = calc_sig(8'h6B, 5) ^ 8'h01;
    session(5, -1);
    repeat (2) step(2'b11, 8'h44, 1'b0, 1'b0, '0, "R10");

    // Zero-length session compares the held contents.
    expect_sig = m_q;
    session(0, -1);
    step(2'b00, 8'h0F, 1'b0, 1'b0, '0, "R10");

    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule